// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This block is a register-mapped mailbox through which several processors pass 32-bit words to each other. It holds a set of small hardware queues. A bus master writes a word into a queue's message register to post it. The receiving processor reads the same register to take the oldest word out. Per-queue registers report whether a queue is full and how many words it holds.

Every user (processor) has its own interrupt status register, its own enable register and its own interrupt line. Each queue contributes two events to every user's status register: a new word arrived, and the queue left the full condition. Software clears status bits by writing ones to them. A line is raised while any enabled status bit of its user is set.

A system configuration register keeps an auto-idle flag and an idle-mode field, and it can launch a soft reset. A controller with two states runs the soft reset. `ST_ACTIVE` is the normal state. A write with the reset bit set moves it to `ST_FLUSH`. It stays in `ST_FLUSH` for `SRST_CYCLES` cycles and then returns to `ST_ACTIVE`. The system status register reports reset completion only in `ST_ACTIVE`. A revision register holds fixed major and minor numbers.

Top module: `ipc_mailbox`

## Requirements
- R1: Writing the message register of queue m (byte offset 0x040 + 4*m) appends the write data. Reading it returns the oldest word and removes it, so words come out in the order they were written. A read and a write to the same message register in one cycle are both carried out: the read sees the word at the head before the write, and a full queue accepts the new word because the read frees a slot.
- R2: A write to a full queue (DEPTH words, default 4) without a simultaneous read is dropped. The queue status register at 0x080 + 4*m reads 1 when the queue is full and 0 otherwise.
- R3: The count register at 0x0C0 + 4*m reads the number of stored words. A read of an empty queue's message register returns 0 and leaves the count and all status bits unchanged.
- R4: The interrupt status register of user u is at 0x100 + 8*u. Every accepted write into queue m sets bit 2*m in the status register of every user.
- R5: A read that takes queue m from full to not full, with no write accepted in the same cycle, sets bit 2*m+1 in every user's status register.
- R6: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: The enable register of user u is at 0x104 + 8*u and reads back what was written. Output irq_o[u] is 1 exactly when the bitwise AND of user u's status and enable registers is nonzero.
- R8: Offset 0x000 reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, with all other bits zero.
- R9: The configuration register at 0x010 stores the auto-idle flag in bit 0 and a 2-bit idle mode in bits 4:3, and reads them back. Bit 1 reads 1 while a soft reset is in progress. All other bits read 0.
- R10: A write to 0x010 with bit 1 set starts a soft reset. That write empties all queues and clears all status, enable and configuration bits. For the next SRST_CYCLES cycles, bit 0 of the status register at 0x014 reads 0 and bus writes have no effect. After that, the bit reads 1 again.
- R11: After a hardware reset, all queues are empty, all status and enable bits are 0, the configuration register reads 0, the register at 0x014 reads 1, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe; a read of a message register removes a word |
| bus_rdata | output | DW | Read data, valid in the cycle of bus_rd |
| irq_o | output | N_USER | Per-user interrupt line |

## Verification
The bus has a single address, so two operations can coincide on one queue: a write and a read of the same message register in the same cycle. The bench provokes this directly on a full queue and on an empty queue, and again at random. On a full queue, the read returns the old head, the new word is kept, the count stays at DEPTH, and only the new-message bit sets. On an empty queue, the read returns 0 and the count becomes 1. A reference model in the bench, updated once per cycle, judges every read value and both interrupt lines against the rules above.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_FLUSH  = 1'b1
    } mbx_state_e;

    localparam int OFS_REVISION = 'h000;
    localparam int OFS_SYSCFG   = 'h010;
    localparam int OFS_SYSSTAT  = 'h014;

    localparam int CFG_AUTO_BIT = 0;
    localparam int CFG_SRST_BIT = 1;
    localparam int CFG_IDLE_LSB = 3;

    function automatic int ofs_msg(input int m);
        return 'h040 + 4 * m;
    endfunction

    function automatic int ofs_qstat(input int m);
        return 'h080 + 4 * m;
    endfunction

    function automatic int ofs_count(input int m);
        return 'h0C0 + 4 * m;
    endfunction

    function automatic int ofs_irqsts(input int u);
        return 'h100 + 8 * u;
    endfunction

    function automatic int ofs_irqen(input int u);
        return 'h104 + 8 * u;
    endfunction

endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       push_ok,
    output logic                       pop_ok
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [NEV-1:0] set_ev,
    input  logic           w1c_we,
    input  logic           en_we,
    input  logic [NEV-1:0] wbits,
    output logic [NEV-1:0] sts,
    output logic [NEV-1:0] en,
    output logic           irq
);

    logic [NEV-1:0] clr_mask;

    assign clr_mask = w1c_we ? wbits : '0;
    assign irq      = |(sts & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else if (clr) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_mask) | set_ev;
            if (en_we) en <= wbits;
        end
    end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import ipc_mailbox_pkg::*;
#(
    parameter int SRST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic flush,
    output logic done
);

    localparam int CTW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;

    mbx_state_e     state;
    mbx_state_e     state_nx;
    logic [CTW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE: state_nx = start ? ST_FLUSH : ST_ACTIVE;
            ST_FLUSH:  state_nx = (cnt == '0) ? ST_ACTIVE : ST_FLUSH;
            default:   state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_ACTIVE && start) cnt <= CTW'(SRST_CYCLES - 1);
            else if (state == ST_FLUSH && cnt != '0) cnt <= cnt - CTW'(1);
        end
    end

    always_comb begin
        flush = 1'b0;
        done  = 1'b1;
        unique case (state)
            ST_ACTIVE: begin
                flush = 1'b0;
                done  = 1'b1;
            end
            ST_FLUSH: begin
                flush = 1'b1;
                done  = 1'b0;
            end
            default: begin
                flush = 1'b0;
                done  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int DW          = 32,
    parameter int ADDR_W      = 12,
    parameter int N_Q         = 4,
    parameter int DEPTH       = 4,
    parameter int N_USER      = 2,
    parameter int SRST_CYCLES = 3,
    parameter int REV_MAJOR   = 1,
    parameter int REV_MINOR   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_USER-1:0] irq_o
);

    localparam int NEV = 2 * N_Q;
    localparam int CW  = $clog2(DEPTH + 1);

    logic [31:0] addr_w;

    logic              hit_rev, hit_cfg, hit_sst;
    logic [N_Q-1:0]    hit_msg, hit_qst, hit_cnt;
    logic [N_USER-1:0] hit_sts, hit_en;

    logic [N_Q-1:0] q_push, q_pop, q_full, q_empty, q_push_ok, q_pop_ok;
    logic [DW-1:0]  q_head  [N_Q];
    logic [CW-1:0]  q_count [N_Q];

    logic [NEV-1:0] ev;
    logic [NEV-1:0] u_sts [N_USER];
    logic [NEV-1:0] u_en  [N_USER];

    logic       flush, done, srst_start, q_clr;
    logic       cfg_auto;
    logic [1:0] cfg_idle;

    assign addr_w = {{(32 - ADDR_W){1'b0}}, bus_addr};

    always_comb begin
        hit_rev = (addr_w == 32'(OFS_REVISION));
        hit_cfg = (addr_w == 32'(OFS_SYSCFG));
        hit_sst = (addr_w == 32'(OFS_SYSSTAT));
        for (int m = 0; m < N_Q; m++) begin
            hit_msg[m] = (addr_w == 32'(ofs_msg(m)));
            hit_qst[m] = (addr_w == 32'(ofs_qstat(m)));
            hit_cnt[m] = (addr_w == 32'(ofs_count(m)));
        end
        for (int u = 0; u < N_USER; u++) begin
            hit_sts[u] = (addr_w == 32'(ofs_irqsts(u)));
            hit_en[u]  = (addr_w == 32'(ofs_irqen(u)));
        end
    end

    assign srst_start = bus_wr & hit_cfg & bus_wdata[CFG_SRST_BIT] & ~flush;
    assign q_clr      = flush | srst_start;

    mbx_ctrl #(
        .SRST_CYCLES(SRST_CYCLES)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(srst_start),
        .flush(flush),
        .done (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_auto <= 1'b0;
            cfg_idle <= 2'b00;
        end else if (q_clr) begin
            cfg_auto <= 1'b0;
            cfg_idle <= 2'b00;
        end else if (bus_wr && hit_cfg) begin
            cfg_auto <= bus_wdata[CFG_AUTO_BIT];
            cfg_idle <= bus_wdata[CFG_IDLE_LSB +: 2];
        end
    end

    for (genvar m = 0; m < N_Q; m++) begin : g_queue
        assign q_push[m] = bus_wr & hit_msg[m] & ~flush;
        assign q_pop[m]  = bus_rd & hit_msg[m] & ~flush;

        mbx_queue #(
            .DW   (DW),
            .DEPTH(DEPTH)
        ) u_queue (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (q_clr),
            .push   (q_push[m]),
            .pop    (q_pop[m]),
            .wdata  (bus_wdata),
            .head   (q_head[m]),
            .count  (q_count[m]),
            .full   (q_full[m]),
            .empty  (q_empty[m]),
            .push_ok(q_push_ok[m]),
            .pop_ok (q_pop_ok[m])
        );

        assign ev[2*m]   = q_push_ok[m];
        assign ev[2*m+1] = q_pop_ok[m] & q_full[m] & ~q_push_ok[m];
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_user
        mbx_irq_bank #(
            .NEV(NEV)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (q_clr),
            .set_ev(ev),
            .w1c_we(bus_wr & hit_sts[u] & ~flush),
            .en_we (bus_wr & hit_en[u] & ~flush),
            .wbits (bus_wdata[NEV-1:0]),
            .sts   (u_sts[u]),
            .en    (u_en[u]),
            .irq   (irq_o[u])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_rev) begin
                bus_rdata[7:4] = 4'(REV_MAJOR);
                bus_rdata[3:0] = 4'(REV_MINOR);
            end
            if (hit_cfg) begin
                bus_rdata[CFG_AUTO_BIT]        = cfg_auto;
                bus_rdata[CFG_SRST_BIT]        = flush;
                bus_rdata[CFG_IDLE_LSB +: 2]   = cfg_idle;
            end
            if (hit_sst) bus_rdata[0] = done;
            for (int m = 0; m < N_Q; m++) begin
                if (hit_msg[m] && !q_empty[m]) bus_rdata = q_head[m];
                if (hit_qst[m]) bus_rdata[0] = q_full[m];
                if (hit_cnt[m]) bus_rdata[CW-1:0] = q_count[m];
            end
            for (int u = 0; u < N_USER; u++) begin
                if (hit_sts[u]) bus_rdata[NEV-1:0] = u_sts[u];
                if (hit_en[u])  bus_rdata[NEV-1:0] = u_en[u];
            end
        end
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 12,
    parameter int N_Q    = 4,
    parameter int N_USER = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_rdata,
    input logic [N_USER-1:0] irq_o,
    input logic              flush,
    input logic [N_Q-1:0]    q_full,
    input logic [N_Q-1:0]    q_empty
);

    logic [31:0] a32;
    assign a32 = {{(32 - ADDR_W){1'b0}}, bus_addr};

    for (genvar m = 0; m < N_Q; m++) begin : g_q
        // R2
        drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !bus_rd && !flush && q_full[m] && a32 == 32'(ofs_msg(m)))
            |=> q_full[m]);

        // R3
        empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && q_empty[m] && a32 == 32'(ofs_msg(m))) |-> (bus_rdata == '0));

        // R3
        empty_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && q_empty[m] && a32 == 32'(ofs_msg(m))) |=> q_empty[m]);

        // R1
        full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(q_full[m] && q_empty[m]));
    end

    // R10
    flush_quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (irq_o == '0));

    // R10
    flush_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && bus_rd && a32 == 32'(OFS_SYSSTAT)) |-> (bus_rdata == '0));

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .DW    (DW),
    .ADDR_W(ADDR_W),
    .N_Q   (N_Q),
    .N_USER(N_USER)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .flush    (flush),
    .q_full   (q_full),
    .q_empty  (q_empty)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int NQ   = 4;
    localparam int DEP  = 4;
    localparam int NU   = 2;
    localparam int SRST = 3;
    localparam int RMAJ = 2;
    localparam int RMIN = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [NU-1:0] irq_o;

    always #2 clk = ~clk;

    ipc_mailbox #(
        .DW(32), .ADDR_W(12), .N_Q(NQ), .DEPTH(DEP), .N_USER(NU),
        .SRST_CYCLES(SRST), .REV_MAJOR(RMAJ), .REV_MINOR(RMIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    bit [31:0] mq [NQ][$];
    bit [7:0]  msts [NU];
    bit [7:0]  men  [NU];
    bit        m_auto;
    bit [1:0]  m_idle;
    int        flush_left;

    function automatic logic [11:0] a_msg(int m); return 12'(32'h040 + 4*m); endfunction
    function automatic logic [11:0] a_qst(int m); return 12'(32'h080 + 4*m); endfunction
    function automatic logic [11:0] a_cnt(int m); return 12'(32'h0C0 + 4*m); endfunction
    function automatic logic [11:0] a_sts(int u); return 12'(32'h100 + 8*u); endfunction
    function automatic logic [11:0] a_en(int u);  return 12'(32'h104 + 8*u); endfunction

    function automatic string tag_of(logic [11:0] a);
        if (a == 12'h000) return "R8";
        if (a == 12'h010) return "R9";
        if (a == 12'h014) return "R10";
        if (a >= 12'h040 && a < 12'h080) return "R1";
        if (a >= 12'h080 && a < 12'h0C0) return "R2";
        if (a >= 12'h0C0 && a < 12'h100) return "R3";
        return "R4";
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        if (a == 12'h000) return 32'((RMAJ << 4) | RMIN);
        if (a == 12'h010) return {27'b0, m_idle, 1'b0, (flush_left > 0), m_auto};
        if (a == 12'h014) return {31'b0, (flush_left == 0)};
        for (int m = 0; m < NQ; m++) begin
            if (a == a_msg(m)) return (mq[m].size() == 0) ? 32'h0 : mq[m][0];
            if (a == a_qst(m)) return {31'b0, (mq[m].size() == DEP)};
            if (a == a_cnt(m)) return 32'(mq[m].size());
        end
        for (int u = 0; u < NU; u++) begin
            if (a == a_sts(u)) return {24'b0, msts[u]};
            if (a == a_en(u))  return {24'b0, men[u]};
        end
        return 32'h0;
    endfunction

    task automatic clear_model();
        for (int m = 0; m < NQ; m++) mq[m].delete();
        for (int u = 0; u < NU; u++) begin msts[u] = 8'h0; men[u] = 8'h0; end
        m_auto = 1'b0;
        m_idle = 2'b00;
    endtask

    task automatic model_update(bit w, bit r, logic [11:0] a, logic [31:0] d);
        if (flush_left > 0) begin
            flush_left--;
            return;
        end
        for (int m = 0; m < NQ; m++) begin
            if (a == a_msg(m)) begin
                bit was_full, popped, pushed;
                was_full = (mq[m].size() == DEP);
                popped   = r && (mq[m].size() > 0);
                if (popped) void'(mq[m].pop_front());
                pushed = w && (mq[m].size() < DEP);
                if (pushed) mq[m].push_back(d);
                for (int u = 0; u < NU; u++) begin
                    if (pushed) msts[u][2*m] = 1'b1;
                    if (popped && was_full && !pushed) msts[u][2*m+1] = 1'b1;
                end
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (w && a == a_sts(u)) msts[u] = msts[u] & ~d[7:0];
            if (w && a == a_en(u))  men[u]  = d[7:0];
        end
        if (w && a == 12'h010) begin
            if (d[1]) begin
                clear_model();
                flush_left = SRST;
            end else begin
                m_auto = d[0];
                m_idle = d[4:3];
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic op(bit w, bit r, logic [11:0] a, logic [31:0] d, string tag);
        logic [NU-1:0] ei;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1;
        for (int u = 0; u < NU; u++) ei[u] = |(msts[u] & men[u]);
        check("R7", 32'(irq_o), 32'(ei), "interrupt lines");
        if (r) check((tag == "") ? tag_of(a) : tag, bus_rdata, exp_rd(a),
                     $sformatf("read of offset %h", a));
        @(posedge clk);
        model_update(w, r, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        flush_left = 0;
        clear_model();
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state, R8 revision
        op(0, 1, 12'h000, 0, "R8");
        op(0, 1, 12'h014, 0, "R11");
        op(0, 1, 12'h010, 0, "R11");
        op(0, 1, a_cnt(0), 0, "R11");
        op(0, 1, a_sts(0), 0, "R11");
        op(0, 1, a_en(1), 0, "R11");

        // R7 enables
        op(1, 0, a_en(0), 32'hFF, "R7");
        op(0, 1, a_en(0), 0, "R7");

        // R2 fill queue 1 and overflow it
        for (int i = 0; i < 5; i++) op(1, 0, a_msg(1), 32'hA000 + i, "R2");
        op(0, 1, a_qst(1), 0, "R2");
        op(0, 1, a_cnt(1), 0, "R3");
        op(0, 1, a_sts(1), 0, "R4");

        // R6 write-one-to-clear
        op(1, 0, a_sts(0), 32'h0, "R6");
        op(0, 1, a_sts(0), 0, "R6");
        op(1, 0, a_sts(0), 32'h4, "R6");
        op(0, 1, a_sts(0), 0, "R6");

        // R1 simultaneous read and write on a full queue
        op(1, 1, a_msg(1), 32'hBEEF, "R1");
        op(0, 1, a_cnt(1), 0, "R1");
        op(0, 1, a_sts(0), 0, "R5");

        // R1 ordered drain, R5 not-full event
        for (int i = 0; i < 4; i++) begin
            op(0, 1, a_msg(1), 0, "R1");
            if (i == 0) op(0, 1, a_sts(1), 0, "R5");
        end
        op(0, 1, a_qst(1), 0, "R2");

        // R3 empty read
        op(0, 1, a_msg(1), 0, "R3");
        op(0, 1, a_cnt(1), 0, "R3");
        op(0, 1, a_sts(1), 0, "R3");

        // R1 simultaneous read and write on an empty queue
        op(1, 1, a_msg(2), 32'h55, "R1");
        op(0, 1, a_cnt(2), 0, "R1");

        // R9 configuration fields
        op(1, 0, 12'h010, 32'h19, "R9");
        op(0, 1, 12'h010, 0, "R9");

        // R10 soft reset sequence
        op(1, 0, a_en(1), 32'h0F, "R10");
        op(1, 0, 12'h010, 32'h2, "R10");
        op(0, 1, 12'h014, 0, "R10");
        op(1, 0, a_msg(0), 32'h77, "R10");
        op(0, 1, 12'h010, 0, "R10");
        op(0, 1, 12'h014, 0, "R10");
        op(0, 1, a_cnt(0), 0, "R10");
        op(0, 1, a_cnt(2), 0, "R10");
        op(0, 1, a_en(0), 0, "R10");
        op(0, 1, a_sts(1), 0, "R10");

        // mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            int k, q, u;
            k = $urandom % 100;
            q = $urandom % NQ;
            u = $urandom % NU;
            if (k < 30)      op(1, 0, a_msg(q), $urandom, "R1");
            else if (k < 50) op(0, 1, a_msg(q), 0, "R1");
            else if (k < 58) op(1, 1, a_msg(q), $urandom, "R1");
            else if (k < 66) op(0, 1, a_qst(q), 0, "R2");
            else if (k < 74) op(0, 1, a_cnt(q), 0, "R3");
            else if (k < 82) op(0, 1, a_sts(u), 0, "R5");
            else if (k < 88) op(1, 0, a_sts(u), $urandom & 32'hFF, "R6");
            else if (k < 93) op(1, 0, a_en(u), $urandom & 32'hFF, "R7");
            else if (k < 97) op(0, 1, a_en(u), 0, "R7");
            else if (k < 99) op(0, 1, ($urandom % 2) ? 12'h010 : 12'h014, 0, "R9");
            else             op(1, 0, 12'h010, 32'h2, "R10");
        end

        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule